// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block keeps the per-line state of one eight-input interrupt controller and decides, every cycle, whether the processor should be interrupted. It holds three registers: the pending requests, the mask, and the in-service set. A fourth register stores the previous input level of each line. Each line is captured either on a rising transition or by level, and a per-line trigger-mode input chooses which.

Resolution is purely combinational from the registered state. The block scans the unmasked pending lines, starting at a programmable 3-bit rotation base. It then scans the in-service lines in the same way. It raises an interrupt request only when the best pending line outranks every line in service.

When special nested mode is enabled on a master instance, the cascade line's in-service bit is left out of the in-service scan. This lets a further request from the cascaded controller get through. Register programming, vector formation and the cascade itself live outside this block. The acknowledge, end-of-service, mask and base strobes arrive from those neighbours.

Top module: `prio_resolver`

## Requirements
- R1: A synchronous active-high reset clears the pending, mask, in-service and last-level registers, sets the rotation base to 0 and drives `int_req` low.
- R2: A line whose `trig_level` bit is 0 sets its pending bit at the first clock edge where its input is high and was low at the previous edge. Holding the input high sets nothing new. An acknowledge of that line clears the bit, unless a new rising transition arrives in the same cycle.
- R3: A line whose `trig_level` bit is 1 has its pending bit equal to its input as sampled at the previous clock edge.
- R4: A pending bit on a line whose mask bit is 1 is still recorded in `pend_o`, but that line is never reported as selected.
- R5: Priority rotates from the base. The line at offset k (k = (line − base) mod 8) has priority k, and 0 is the best. `sel_line` gives the best unmasked pending line as (priority + base) mod 8.
- R6: With no unmasked pending line, the scan finds nothing (priority value 8) and `sel_valid` is low.
- R7: `sel_valid` is high only when the best pending priority is strictly smaller than the best in-service priority. An equal or larger value gives no request.
- R8: When `sfnm_en` is 1 and the instance is the master, in-service bit 2 (the cascade line) is ignored in the in-service scan.
- R9: `int_req` equals the value `sel_valid` had in the previous cycle.
- R10: `ack_valid` sets in-service bit `ack_line` at the next edge. It clears that line's pending bit only in edge mode; a level-mode pending bit stays.
- R11: `eoi_valid` clears in-service bit `eoi_line` at the next edge. If an acknowledge of the same line arrives in the same cycle, the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Raw interrupt input levels |
| trig_level | input | 8 | Per-line trigger mode, 1 = level, 0 = rising edge |
| mask_we | input | 1 | Load the mask register |
| mask_din | input | 8 | New mask, 1 = line masked |
| base_we | input | 1 | Load the rotation base |
| base_din | input | 3 | New rotation base |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | 3 | Line being acknowledged |
| eoi_valid | input | 1 | End-of-service strobe |
| eoi_line | input | 3 | Line whose service ends |
| sfnm_en | input | 1 | Special nested mode enable |
| int_req | output | 1 | Registered interrupt request |
| sel_valid | output | 1 | A pending line outranks the in-service set |
| sel_line | output | 3 | Best unmasked pending line |
| pend_o | output | 8 | Pending request register |
| insvc_o | output | 8 | In-service register |

## Verification
Some properties are checked on every cycle. These cover the reset values, level-mode pending bits tracking their input, and rising transitions setting the pending bit. They also cover the selected line being unmasked and pending, the one-cycle lag of `int_req`, and the effect of acknowledge and end-of-service on the in-service set. Other behaviour can only be shown by the bench's scenarios, because it depends on a chosen history of state. This includes the rotation order under different bases and the rule that equal priority gives no request. It also includes special nested mode letting the cascade line or a lower line through, and a masked request appearing only once the mask is lifted.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int PRIO_W = $clog2(LINES + 1);

    typedef logic [LINES-1:0]  vec_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [PRIO_W-1:0] prio_t;

    // Result of one rotated priority scan; prio == LINES means empty.
    typedef struct packed {
        logic  hit;
        idx_t  line;
        prio_t prio;
    } scan_t;

    function automatic vec_t line_bit(input idx_t i);
        vec_t v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    // Line index at a given offset from the base; wraps since LINES is a power of two.
    function automatic idx_t rotate(input idx_t base, input int unsigned off);
        return idx_t'(base + idx_t'(off));
    endfunction
endpackage

// File: rtl/prio_res_scan.sv
module prio_res_scan
    import prio_res_pkg::*;
(
    input  vec_t  req,
    input  idx_t  base,
    output scan_t res
);
    // Walk from the worst offset to the best so the best hit is written last.
    always_comb begin
        res.hit  = 1'b0;
        res.line = base;
        res.prio = prio_t'(LINES);
        for (int k = LINES - 1; k >= 0; k--) begin
            if (req[rotate(base, k)]) begin
                res.hit  = 1'b1;
                res.line = rotate(base, k);
                res.prio = prio_t'(k);
            end
        end
    end
endmodule

// File: rtl/prio_res_capture.sv
module prio_res_capture
    import prio_res_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  vec_t lvl_in,
    input  vec_t trig_lvl,
    input  vec_t ack_clr,
    output vec_t pend,
    output vec_t last_lvl
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic rise;
        logic nxt;

        always_comb begin
            rise = lvl_in[g] & ~last_lvl[g];
            if (trig_lvl[g]) begin
                nxt = lvl_in[g];
            end else begin
                nxt = (pend[g] & ~ack_clr[g]) | rise;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pend[g]     <= 1'b0;
                last_lvl[g] <= 1'b0;
            end else begin
                pend[g]     <= nxt;
                last_lvl[g] <= lvl_in[g];
            end
        end
    end
endmodule

// File: rtl/prio_res_insvc.sv
module prio_res_insvc
    import prio_res_pkg::*;
#(
    parameter bit IS_MASTER    = 1'b1,
    parameter int CASCADE_LINE = 2
) (
    input  logic clk,
    input  logic rst,
    input  vec_t set_vec,
    input  vec_t clr_vec,
    input  logic sfnm_en,
    output vec_t insvc,
    output vec_t rank_mask
);
    localparam vec_t CASCADE_BIT = vec_t'(1) << CASCADE_LINE;

    always_ff @(posedge clk) begin
        if (rst) begin
            insvc <= '0;
        end else begin
            insvc <= (insvc & ~clr_vec) | set_vec;
        end
    end

    if (IS_MASTER) begin : g_master
        assign rank_mask = sfnm_en ? (insvc & ~CASCADE_BIT) : insvc;
    end else begin : g_slave
        assign rank_mask = insvc;
    end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_res_pkg::*;
#(
    parameter bit IS_MASTER    = 1'b1,
    parameter int CASCADE_LINE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] trig_level,
    input  logic             mask_we,
    input  logic [LINES-1:0] mask_din,
    input  logic             base_we,
    input  logic [IDX_W-1:0] base_din,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_line,
    input  logic             eoi_valid,
    input  logic [IDX_W-1:0] eoi_line,
    input  logic             sfnm_en,
    output logic             int_req,
    output logic             sel_valid,
    output logic [IDX_W-1:0] sel_line,
    output logic [LINES-1:0] pend_o,
    output logic [LINES-1:0] insvc_o
);
    vec_t  imr_q;
    idx_t  base_q;
    vec_t  pend;
    vec_t  last_lvl;
    vec_t  insvc;
    vec_t  rank_mask;
    vec_t  ack_vec;
    vec_t  eoi_vec;
    vec_t  live_req;
    scan_t best_req;
    scan_t best_svc;

    assign ack_vec  = ack_valid ? line_bit(ack_line) : '0;
    assign eoi_vec  = eoi_valid ? line_bit(eoi_line) : '0;
    assign live_req = pend & ~imr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            imr_q  <= '0;
            base_q <= '0;
        end else begin
            if (mask_we) imr_q  <= mask_din;
            if (base_we) base_q <= base_din;
        end
    end

    prio_res_capture i_capture (
        .clk      (clk),
        .rst      (rst),
        .lvl_in   (irq_in),
        .trig_lvl (trig_level),
        .ack_clr  (ack_vec),
        .pend     (pend),
        .last_lvl (last_lvl)
    );

    prio_res_insvc #(
        .IS_MASTER    (IS_MASTER),
        .CASCADE_LINE (CASCADE_LINE)
    ) i_insvc (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (ack_vec),
        .clr_vec   (eoi_vec),
        .sfnm_en   (sfnm_en),
        .insvc     (insvc),
        .rank_mask (rank_mask)
    );

    prio_res_scan i_scan_req (
        .req  (live_req),
        .base (base_q),
        .res  (best_req)
    );

    prio_res_scan i_scan_svc (
        .req  (rank_mask),
        .base (base_q),
        .res  (best_svc)
    );

    // Strictly better than the best in-service line; an empty scan ranks as LINES.
    assign sel_valid = best_req.hit && (best_req.prio < best_svc.prio);
    assign sel_line  = best_req.line;
    assign pend_o    = pend;
    assign insvc_o   = insvc;

    always_ff @(posedge clk) begin
        if (rst) begin
            int_req <= 1'b0;
        end else begin
            int_req <= sel_valid;
        end
    end
endmodule

// File: rtl/prio_res_check.sv
module prio_res_check
    import prio_res_pkg::*;
(
    input logic clk,
    input logic rst,
    input vec_t irq_in,
    input vec_t trig_level,
    input vec_t last_lvl,
    input vec_t pend,
    input vec_t insvc,
    input vec_t imr,
    input idx_t base,
    input logic ack_valid,
    input idx_t ack_line,
    input logic eoi_valid,
    input idx_t eoi_line,
    input logic sfnm_en,
    input logic sel_valid,
    input idx_t sel_line,
    input logic int_req
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (pend == '0 && insvc == '0 && imr == '0 && base == '0 && !int_req));

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend & $past(irq_in & ~last_lvl & ~trig_level))
                         == $past(irq_in & ~last_lvl & ~trig_level)));

    assert_level_follows_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend & $past(trig_level)) == ($past(irq_in) & $past(trig_level))));

    assert_sel_unmasked_R4: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> (!imr[sel_line] && pend[sel_line]));

    assert_sel_not_in_service_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && !sfnm_en) |-> !insvc[sel_line]);

    assert_req_lag_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (int_req == $past(sel_valid)));

    assert_ack_sets_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ack_valid)) |-> insvc[$past(ack_line)]);

    assert_eoi_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(eoi_valid) && !($past(ack_valid) && $past(ack_line) == $past(eoi_line)))
        |-> !insvc[$past(eoi_line)]);
endmodule

bind prio_resolver prio_res_check i_prio_res_check (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .trig_level (trig_level),
    .last_lvl   (last_lvl),
    .pend       (pend),
    .insvc      (insvc),
    .imr        (imr_q),
    .base       (base_q),
    .ack_valid  (ack_valid),
    .ack_line   (ack_line),
    .eoi_valid  (eoi_valid),
    .eoi_line   (eoi_line),
    .sfnm_en    (sfnm_en),
    .sel_valid  (sel_valid),
    .sel_line   (sel_line),
    .int_req    (int_req)
);

// File: tb/test_prio_resolver.sv
`timescale 1ns/1ps
module test_prio_resolver;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in, trig_level, mask_din;
    logic       mask_we, base_we, ack_valid, eoi_valid, sfnm_en;
    logic [2:0] base_din, ack_line, eoi_line;
    logic       int_req, sel_valid;
    logic [2:0] sel_line;
    logic [7:0] pend_o, insvc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        logic       valid;
        logic [2:0] line;
        logic [7:0] irr;
        logic [7:0] isr;
        logic       intr;
    } exp_t;
    exp_t sb[$];

    // Reference state, built from the requirements.
    logic [7:0] m_irr = '0, m_last = '0, m_isr = '0, m_imr = '0;
    logic [2:0] m_base = '0;
    logic       m_int = 1'b0;

    always #4 clk = ~clk;

    prio_resolver i_prio_resolver (
        .clk(clk), .rst(rst), .irq_in(irq_in), .trig_level(trig_level),
        .mask_we(mask_we), .mask_din(mask_din), .base_we(base_we), .base_din(base_din),
        .ack_valid(ack_valid), .ack_line(ack_line), .eoi_valid(eoi_valid), .eoi_line(eoi_line),
        .sfnm_en(sfnm_en), .int_req(int_req), .sel_valid(sel_valid), .sel_line(sel_line),
        .pend_o(pend_o), .insvc_o(insvc_o)
    );

    function automatic int best_prio(input logic [7:0] v, input logic [2:0] b);
        for (int k = 0; k < 8; k++) begin
            if (v[3'(b + 3'(k))]) return k;
        end
        return 8;
    endfunction

    task automatic m_resolve(output logic v, output logic [2:0] ln);
        int pp, cp;
        logic [7:0] svc;
        svc = sfnm_en ? (m_isr & 8'hFB) : m_isr;
        pp  = best_prio(m_irr & ~m_imr, m_base);
        cp  = best_prio(svc, m_base);
        v   = (pp < cp);
        ln  = 3'(m_base + 3'(pp));
    endtask

    task automatic step(input string tag);
        logic v0, v1;
        logic [2:0] l0, l1;
        logic [7:0] rise, ackv, eoiv;
        exp_t e;
        @(posedge clk);
        m_resolve(v0, l0);
        if (rst) begin
            m_irr = '0; m_last = '0; m_isr = '0; m_imr = '0; m_base = '0; m_int = 1'b0;
        end else begin
            rise   = irq_in & ~m_last & ~trig_level;
            ackv   = ack_valid ? (8'b1 << ack_line) : 8'h00;
            eoiv   = eoi_valid ? (8'b1 << eoi_line) : 8'h00;
            m_irr  = (trig_level & irq_in) | (~trig_level & ((m_irr & ~ackv) | rise));
            m_last = irq_in;
            m_isr  = (m_isr & ~eoiv) | ackv;
            if (mask_we) m_imr = mask_din;
            if (base_we) m_base = base_din;
            m_int  = v0;
        end
        m_resolve(v1, l1);
        e.tag = tag; e.valid = v1; e.line = l1; e.irr = m_irr; e.isr = m_isr; e.intr = m_int;
        sb.push_back(e);
        @(negedge clk);
        #2;
        ack_valid = 1'b0; eoi_valid = 1'b0; mask_we = 1'b0; base_we = 1'b0;
    endtask

    // Monitor: pops one expected item per cycle and compares it with the ports.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (sel_valid !== e.valid || (e.valid && sel_line !== e.line) ||
                pend_o !== e.irr || insvc_o !== e.isr || int_req !== e.intr) begin
                fails++;
                $display("FAIL %s: got valid=%b line=%0d pend=%h insvc=%h req=%b exp valid=%b line=%0d pend=%h insvc=%h req=%b",
                         e.tag, sel_valid, sel_line, pend_o, insvc_o, int_req,
                         e.valid, e.line, e.irr, e.isr, e.intr);
            end
        end
    end

    task automatic expect_sel(input string tag, input logic v, input logic [2:0] ln);
        checks++;
        if (sel_valid !== v || (v && sel_line !== ln)) begin
            fails++;
            $display("FAIL %s: got valid=%b line=%0d exp valid=%b line=%0d", tag, sel_valid, sel_line, v, ln);
        end
    endtask

    task automatic expect_req(input string tag, input logic v);
        checks++;
        if (int_req !== v) begin
            fails++;
            $display("FAIL %s: got int_req=%b exp %b", tag, int_req, v);
        end
    endtask

    task automatic ack(input logic [2:0] l); ack_valid = 1'b1; ack_line = l; endtask
    task automatic eoi(input logic [2:0] l); eoi_valid = 1'b1; eoi_line = l; endtask

    initial begin
        rst = 1'b1; irq_in = '0; trig_level = '0; mask_we = 0; mask_din = '0;
        base_we = 0; base_din = '0; ack_valid = 0; ack_line = '0; eoi_valid = 0;
        eoi_line = '0; sfnm_en = 0;
        #2;
        step("R1 reset"); step("R1 reset");
        rst = 1'b0;
        expect_sel("R1 idle after reset", 1'b0, 3'd0);
        expect_req("R1 int_req low", 1'b0);

        // Edge mode, acknowledge, equal priority, end of service
        irq_in[3] = 1'b1; step("R2 rising edge");
        expect_sel("R2 line 3 selected", 1'b1, 3'd3);
        expect_req("R9 request lags one cycle", 1'b0);
        step("R2 held high");
        expect_req("R9 request follows", 1'b1);
        ack(3); step("R10 ack edge line");
        expect_sel("R10 edge pending cleared", 1'b0, 3'd0);
        step("R2 held, no new edge");
        irq_in[3] = 1'b0; step("R2 low");
        irq_in[3] = 1'b1; step("R7 equal priority");
        expect_sel("R7 equal gives no request", 1'b0, 3'd0);
        eoi(3); step("R11 eoi");
        expect_sel("R11 line 3 again after eoi", 1'b1, 3'd3);
        ack(3); step("R10 ack again");
        irq_in[3] = 1'b0; eoi(3); step("R11 clean");

        // Level mode
        trig_level = 8'h20; irq_in[5] = 1'b1; step("R3 level high");
        expect_sel("R3 level line 5", 1'b1, 3'd5);
        ack(5); step("R10 level kept on ack");
        irq_in[5] = 1'b0; step("R3 level low clears");
        eoi(5); step("R11 clean level");
        trig_level = 8'h00; step("R3 back to edge");

        // Masked request
        mask_we = 1'b1; mask_din = 8'h02; step("R4 set mask");
        irq_in[1] = 1'b1; step("R4 masked recorded");
        expect_sel("R4 masked not selected", 1'b0, 3'd0);
        mask_we = 1'b1; mask_din = 8'h00; step("R4 unmask");
        expect_sel("R4 selected after unmask", 1'b1, 3'd1);
        ack(1); step("R4 clean ack");
        irq_in[1] = 1'b0; eoi(1); step("R4 clean eoi");

        // Rotation
        base_we = 1'b1; base_din = 3'd5; step("R5 base 5");
        irq_in = 8'h42; step("R5 lines 1 and 6");
        expect_sel("R5 base 5 picks 6", 1'b1, 3'd6);
        base_we = 1'b1; base_din = 3'd0; step("R5 base 0");
        expect_sel("R5 base 0 picks 1", 1'b1, 3'd1);
        base_we = 1'b1; base_din = 3'd3; step("R5 base 3");
        expect_sel("R5 base 3 picks 6", 1'b1, 3'd6);
        irq_in = 8'h00; ack(6); step("R5 clean");
        ack(1); step("R5 clean");
        eoi(6); step("R5 clean");
        eoi(1); step("R5 clean");
        base_we = 1'b1; base_din = 3'd0; step("R5 base reset");

        // Special nested mode
        irq_in[2] = 1'b1; step("R8 cascade request");
        expect_sel("R8 cascade line selected", 1'b1, 3'd2);
        ack(2); step("R8 cascade in service");
        irq_in[2] = 1'b0; step("R8 cascade low");
        irq_in[4] = 1'b1; step("R7 lower than in-service");
        expect_sel("R7 line 4 blocked", 1'b0, 3'd0);
        sfnm_en = 1'b1; step("R8 nested mode on");
        expect_sel("R8 line 4 passes", 1'b1, 3'd4);
        irq_in[2] = 1'b1; step("R8 cascade again");
        expect_sel("R8 cascade re-request", 1'b1, 3'd2);
        sfnm_en = 1'b0; step("R8 nested mode off");
        expect_sel("R8 off blocks cascade", 1'b0, 3'd0);
        irq_in = 8'h00; ack(2); step("R6 clean");
        ack(4); step("R6 clean");
        eoi(2); step("R6 clean");
        eoi(4); step("R6 clean");
        step("R6 nothing pending");
        expect_sel("R6 empty scan", 1'b0, 3'd0);
        checks++;
        if (pend_o !== 8'h00) begin
            fails++;
            $display("FAIL R6: got pend=%h exp 00", pend_o);
        end

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule